// File: doc/BRIEF.md
# Banked Host Register Interface

This block is an asynchronous 8-bit bus slave for a host processor. The host drives an active-low chip select, active-low read and write strobes, a 5-bit address and 8 data bits. Through a small direct address map it reaches three kinds of resource:

- two larger indirect register spaces, each through a pointer register and a data window;
- the push ports of two input FIFOs and the pop port of one output FIFO;
- two banks of interrupt flags, each with its own enable register.

The strobes are brought into the system clock domain with two flip-flops. Every access takes effect once, on the synchronized release of its strobe. A write uses the address and data that were present while the strobe was low, so the host needs no hold time after it releases the strobe. Read data is a combinational selection of the addressed register and is driven only while chip select and read are both low. The bidirectional pad is outside this block; it is modelled here by a data output and an output-enable.

The active-low interrupt pin goes low when the global interrupt enable is set and any flag bit has its matching enable bit set. Each flag bit is set by a one-cycle event pulse and is cleared when the host writes a 1 to it.

Top module: `hbr_regif`

## Requirements
- R1: After reset:
  - address 0 reads 0x00 (with busy low);
  - all enables and flags read 0;
  - irq_no is 1;
  - data_oe_o is 0 while no read is in progress.
- R2: A write commits exactly once, after the host releases the strobe. It uses the address and data present while the strobe was low; values changed at the moment of release are ignored.
- R3: data_oe_o is 1 only while cs_ni and rd_ni are both 0, and returns to 0 after read is released.
- R4: Address 1 is the pointer for space A and reads back. Address 2 is the window for space A:
  - a write gives one ireg_a_we_o pulse with ireg_a_addr_o equal to the pointer;
  - a read returns ireg_a_rdata_i.
- R5: Address 16 and address 17 form the same pointer and window pair for space B (ireg_b_*).
- R6: A write to address 18 gives exactly one dec_push_o pulse, and a write to address 19 gives exactly one aux_push_o pulse, however long the strobe is held. wdata_o carries the written byte during the pulse.
- R7: A read of address 18 returns rec_rdata_i and gives exactly one rec_pop_o pulse after the strobe is released.
- R8: Address 0 has these fields:
  - bit 7 is the global interrupt enable (read/write);
  - bit 0 is the bank select (read/write, also driven on bank_o);
  - bit 1 is busy_i (read-only);
  - bit 2 is the pending-interrupt status (read-only): any flag AND its enable, across both banks, ignoring bit 7.
- R9: Flag registers sit at address 22 (events evt_i) and address 20 (events dsp_evt_i). A one-cycle event pulse on bit n sets flag bit n. Writing 1 to a bit clears it; writing 0 leaves it unchanged. An event arriving in the same cycle as the clear wins.
- R10: Enable registers sit at address 23 (for flags at 22) and address 21 (for flags at 20). irq_no is 0 exactly when the global enable is set and some flag bit has its enable bit set; otherwise it is 1.
- R11: Address 15 reads a fixed identifier (parameter, default 0x5A) and ignores writes.
- R12: Unmapped addresses (for example 9) read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 5 | Direct register address |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Read data to host |
| data_oe_o | output | 1 | Data pad output enable |
| busy_i | input | 1 | Busy status shown in address 0 |
| evt_i | input | 8 | Event pulses for flag bank at 22 |
| dsp_evt_i | input | 8 | Event pulses for flag bank at 20 |
| irq_no | output | 1 | Interrupt request, active low |
| bank_o | output | 1 | Bank select bit |
| ireg_a_addr_o | output | 8 | Space A register address (pointer) |
| ireg_a_we_o | output | 1 | Space A write pulse |
| ireg_a_rdata_i | input | 8 | Space A read data |
| ireg_b_addr_o | output | 8 | Space B register address (pointer) |
| ireg_b_we_o | output | 1 | Space B write pulse |
| ireg_b_rdata_i | input | 8 | Space B read data |
| wdata_o | output | 8 | Committed write byte for windows and FIFOs |
| dec_push_o | output | 1 | Decode input FIFO push |
| aux_push_o | output | 1 | Second input FIFO push |
| rec_pop_o | output | 1 | Record output FIFO pop |
| rec_rdata_i | input | 8 | Record output FIFO head data |

## Verification
The main function is exercised by a table of write-then-read pairs. The pairs cover every class of address:
- plain registers;
- pointers;
- windows;
- enables;
- the read-only identifier;
- an unmapped address.

The table separates the effect of a stored value from that of a routed value and from that of a value that must be ignored. Each write changes the address and data at the moment the strobe is released. A design that captures late therefore writes the wrong place or the wrong value.

Directed sequences then cover:
- flag set followed by clear, including a write of 0 that must leave the flag alone;
- interrupt pin behaviour with and without the global enable;
- a strobe held for many cycles, which must still push only once;
- pop on a read;
- the output-enable window around a read.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_CTRL   = 5'd0;
  localparam logic [AW-1:0] A_PTR_A  = 5'd1;
  localparam logic [AW-1:0] A_WIN_A  = 5'd2;
  localparam logic [AW-1:0] A_ID     = 5'd15;
  localparam logic [AW-1:0] A_PTR_B  = 5'd16;
  localparam logic [AW-1:0] A_WIN_B  = 5'd17;
  localparam logic [AW-1:0] A_FIFO0  = 5'd18;
  localparam logic [AW-1:0] A_FIFO1  = 5'd19;
  localparam logic [AW-1:0] A_DFLAG  = 5'd20;
  localparam logic [AW-1:0] A_DEN    = 5'd21;
  localparam logic [AW-1:0] A_HFLAG  = 5'd22;
  localparam logic [AW-1:0] A_HEN    = 5'd23;

  function automatic logic is_writable(input logic [AW-1:0] a);
    case (a)
      A_CTRL, A_PTR_A, A_WIN_A, A_PTR_B, A_WIN_B, A_FIFO0, A_FIFO1,
      A_DFLAG, A_DEN, A_HFLAG, A_HEN: is_writable = 1'b1;
      default:                        is_writable = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hbr_strobe_sync.sv
module hbr_strobe_sync #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_commit_o,
  output logic          rd_commit_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  // bit 1: write active, bit 0: read active
  logic [1:0]    s1_q, s2_q, s3_q;
  logic [AW-1:0] a1_q, a2_q, acap_q;
  logic [DW-1:0] d1_q, d2_q, dcap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
      a1_q <= '0; a2_q <= '0; acap_q <= '0;
      d1_q <= '0; d2_q <= '0; dcap_q <= '0;
    end else begin
      s1_q <= {~cs_ni & ~wr_ni, ~cs_ni & ~rd_ni};
      s2_q <= s1_q;
      s3_q <= s2_q;
      a1_q <= addr_i;
      a2_q <= a1_q;
      d1_q <= data_i;
      d2_q <= d1_q;
      // address/data travel with the strobe so zero hold suffices
      if (s2_q[1]) begin
        acap_q <= a2_q;
        dcap_q <= d2_q;
      end else if (s2_q[0]) begin
        acap_q <= a2_q;
      end
    end
  end

  assign wr_commit_o = s3_q[1] & ~s2_q[1];
  assign rd_commit_o = s3_q[0] & ~s2_q[0];
  assign addr_o      = acap_q;
  assign data_o      = dcap_q;

  AST_WR_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o); // R2
  AST_RD_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_commit_o |=> !rd_commit_o); // R7
endmodule

// File: rtl/hbr_flag_bank.sv
module hbr_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);
  logic [W-1:0] flags_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      // set has priority over write-one-to-clear
      flags_q <= (flags_q & ~(clr_we_i ? wdata_i : '0)) | evt_i;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign pend_o  = |(flags_q & en_q);

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R9
  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(wdata_i & ~evt_i)) |=> ((flags_q & $past(wdata_i & ~evt_i)) == '0)); // R9
endmodule

// File: rtl/hbr_regif.sv
module hbr_regif
  import hbr_pkg::*;
#(
  parameter int          PTR_W = 8,
  parameter logic [7:0]  HW_ID = 8'h5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [4:0]       addr_i,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  input  logic             busy_i,
  input  logic [7:0]       evt_i,
  input  logic [7:0]       dsp_evt_i,
  output logic             irq_no,
  output logic             bank_o,
  output logic [PTR_W-1:0] ireg_a_addr_o,
  output logic             ireg_a_we_o,
  input  logic [7:0]       ireg_a_rdata_i,
  output logic [PTR_W-1:0] ireg_b_addr_o,
  output logic             ireg_b_we_o,
  input  logic [7:0]       ireg_b_rdata_i,
  output logic [7:0]       wdata_o,
  output logic             dec_push_o,
  output logic             aux_push_o,
  output logic             rec_pop_o,
  input  logic [7:0]       rec_rdata_i
);
  localparam int NBANK = 2;

  logic          wr_commit, rd_commit;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;

  hbr_strobe_sync #(.AW(AW), .DW(DW)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .addr_i, .data_i,
    .wr_commit_o(wr_commit), .rd_commit_o(rd_commit),
    .addr_o(cap_addr), .data_o(cap_data)
  );

  logic             gie_q, bank_q, irq_nq;
  logic [PTR_W-1:0] ptr_a_q, ptr_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      bank_q  <= 1'b0;
      ptr_a_q <= '0;
      ptr_b_q <= '0;
    end else if (wr_commit) begin
      case (cap_addr)
        A_CTRL:  begin gie_q <= cap_data[7]; bank_q <= cap_data[0]; end
        A_PTR_A: ptr_a_q <= PTR_W'(cap_data);
        A_PTR_B: ptr_b_q <= PTR_W'(cap_data);
        default: ;
      endcase
    end
  end

  // interrupt flag banks: 0 = host events at 22/23, 1 = DSP events at 20/21
  logic [DW-1:0] evt_arr   [NBANK];
  logic [DW-1:0] flags_arr [NBANK];
  logic [DW-1:0] en_arr    [NBANK];
  logic [NBANK-1:0] pend_vec;

  assign evt_arr[0] = evt_i;
  assign evt_arr[1] = dsp_evt_i;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [AW-1:0] FLAG_ADR = (g == 0) ? A_HFLAG : A_DFLAG;
    localparam logic [AW-1:0] EN_ADR   = (g == 0) ? A_HEN   : A_DEN;
    hbr_flag_bank #(.W(DW)) u_bank (
      .clk_i, .rst_ni,
      .evt_i   (evt_arr[g]),
      .clr_we_i(wr_commit && cap_addr == FLAG_ADR),
      .en_we_i (wr_commit && cap_addr == EN_ADR),
      .wdata_i (cap_data),
      .flags_o (flags_arr[g]),
      .en_o    (en_arr[g]),
      .pend_o  (pend_vec[g])
    );
  end

  logic pending;
  assign pending = |pend_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_nq <= 1'b1;
    else         irq_nq <= ~(gie_q & pending);
  end

  assign irq_no        = irq_nq;
  assign bank_o        = bank_q;
  assign ireg_a_addr_o = ptr_a_q;
  assign ireg_b_addr_o = ptr_b_q;
  assign wdata_o       = cap_data;
  assign ireg_a_we_o   = wr_commit && cap_addr == A_WIN_A;
  assign ireg_b_we_o   = wr_commit && cap_addr == A_WIN_B;
  assign dec_push_o    = wr_commit && cap_addr == A_FIFO0;
  assign aux_push_o    = wr_commit && cap_addr == A_FIFO1;
  assign rec_pop_o     = rd_commit && cap_addr == A_FIFO0;

  // asynchronous read path straight from the pins
  logic [7:0] rd_mux;
  always_comb begin
    case (addr_i)
      A_CTRL:  rd_mux = {gie_q, 4'b0, pending, busy_i, bank_q};
      A_PTR_A: rd_mux = 8'(ptr_a_q);
      A_WIN_A: rd_mux = ireg_a_rdata_i;
      A_ID:    rd_mux = HW_ID;
      A_PTR_B: rd_mux = 8'(ptr_b_q);
      A_WIN_B: rd_mux = ireg_b_rdata_i;
      A_FIFO0: rd_mux = rec_rdata_i;
      A_DFLAG: rd_mux = flags_arr[1];
      A_DEN:   rd_mux = en_arr[1];
      A_HFLAG: rd_mux = flags_arr[0];
      A_HEN:   rd_mux = en_arr[0];
      default: rd_mux = 8'h00;
    endcase
  end

  assign data_oe_o = ~cs_ni & ~rd_ni;
  assign data_o    = data_oe_o ? rd_mux : 8'h00;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({dec_push_o, aux_push_o, rec_pop_o, ireg_a_we_o, ireg_b_we_o}) <= 1); // R6
  AST_PUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_push_o |=> !dec_push_o); // R6
  AST_POP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_pop_o |=> !rec_pop_o); // R7
  AST_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_commit && !is_writable(cap_addr)) |=>
      ($stable(ptr_a_q) && $stable(ptr_b_q) && $stable(gie_q) && $stable(bank_q))); // R12
  AST_PTR_HOLD_ON_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ireg_a_we_o |=> $stable(ptr_a_q)); // R4
endmodule

// File: tb/sim_hbr_regif.sv
module sim_hbr_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       oe, busy = 1'b0, irq_n, bank;
  logic [7:0] evt = '0, dsp_evt = '0;
  logic [7:0] a_addr, b_addr, wdata;
  logic       a_we, b_we, dec_push, aux_push, rec_pop;
  logic [7:0] mem_a [256];
  logic [7:0] mem_b [256];
  logic [7:0] rec_head = 8'h77;

  hbr_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .busy_i(busy), .evt_i(evt), .dsp_evt_i(dsp_evt), .irq_no(irq_n), .bank_o(bank),
    .ireg_a_addr_o(a_addr), .ireg_a_we_o(a_we), .ireg_a_rdata_i(mem_a[a_addr]),
    .ireg_b_addr_o(b_addr), .ireg_b_we_o(b_we), .ireg_b_rdata_i(mem_b[b_addr]),
    .wdata_o(wdata), .dec_push_o(dec_push), .aux_push_o(aux_push),
    .rec_pop_o(rec_pop), .rec_rdata_i(rec_head)
  );

  int checks = 0, errors = 0;
  int n_dec = 0, n_aux = 0, n_pop = 0, n_awe = 0;
  logic [7:0] last_dec;

  initial for (int i = 0; i < 256; i++) begin mem_a[i] = '0; mem_b[i] = '0; end

  always @(posedge clk) begin
    if (a_we) begin mem_a[a_addr] <= wdata; n_awe <= n_awe + 1; end
    if (b_we) mem_b[b_addr] <= wdata;
    if (dec_push) begin n_dec <= n_dec + 1; last_dec <= wdata; end
    if (aux_push) n_aux <= n_aux + 1;
    if (rec_pop) n_pop <= n_pop + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // junk on address/data at release checks zero-hold capture
  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d, input int hold = 3);
    @(negedge clk); addr = a; din = d; cs_n = 0; wr_n = 0;
    repeat (hold) @(negedge clk);
    wr_n = 1; cs_n = 1; addr = 5'd9; din = ~d;
    repeat (5) @(negedge clk);
  endtask

  logic rd_oe;
  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; cs_n = 0; rd_n = 0;
    repeat (3) @(negedge clk);
    d = dout; rd_oe = oe;
    rd_n = 1; cs_n = 1;
    repeat (5) @(negedge clk);
  endtask

  // {addr, write data, expected readback}
  localparam logic [20:0] VEC [9] = '{
    {5'd1,  8'h05, 8'h05},   // R4 pointer A
    {5'd2,  8'h3C, 8'h3C},   // R4 window A
    {5'd16, 8'h2A, 8'h2A},   // R5 pointer B
    {5'd17, 8'hC3, 8'hC3},   // R5 window B
    {5'd23, 8'hF0, 8'hF0},   // R10 host enable
    {5'd21, 8'h0F, 8'h0F},   // R10 dsp enable
    {5'd9,  8'hFF, 8'h00},   // R12 unmapped
    {5'd15, 8'h11, 8'h5A},   // R11 identifier
    {5'd0,  8'h81, 8'h81}    // R8 control fields
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [7:0] r;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 irq", irq_n, 1);
    check("R1 oe idle", oe, 0);
    bus_rd(5'd0, r);  check("R1 ctrl", r, 8'h00);
    bus_rd(5'd22, r); check("R1 flags", r, 8'h00);
    bus_rd(5'd23, r); check("R1 enable", r, 8'h00);
    check("R3 oe during read", rd_oe, 1);
    check("R3 oe after read", oe, 0);

    for (int i = 0; i < 9; i++) begin
      bus_wr(VEC[i][20:16], VEC[i][15:8]);
      bus_rd(VEC[i][20:16], r);
      check("R2 vector readback", {VEC[i][20:16], r}, {VEC[i][20:16], VEC[i][7:0]});
    end
    check("R4 one window write", n_awe, 1);
    check("R4 window A stored at pointer", mem_a[5], 8'h3C);
    check("R5 window B stored at pointer", mem_b[8'h2A], 8'hC3);
    check("R8 bank_o", bank, 1);

    // R9 event set, R10 masked by enable
    @(negedge clk); evt = 8'h08; @(negedge clk); evt = 8'h00;
    bus_rd(5'd22, r); check("R9 flag set", r, 8'h08);
    check("R10 masked flag no irq", irq_n, 1);
    bus_wr(5'd23, 8'h08);
    check("R10 irq asserted", irq_n, 0);
    bus_rd(5'd0, r); check("R8 pending bit", r, 8'h85);
    bus_wr(5'd22, 8'h00);
    bus_rd(5'd22, r); check("R9 write zero keeps", r, 8'h08);
    bus_wr(5'd0, 8'h00);
    check("R10 gie off releases irq", irq_n, 1);
    bus_rd(5'd0, r); check("R8 pending ignores gie", r, 8'h04);
    bus_wr(5'd0, 8'h80);
    bus_wr(5'd22, 8'h08);
    bus_rd(5'd22, r); check("R9 w1c", r, 8'h00);
    check("R10 irq released after clear", irq_n, 1);

    // R9 set wins over simultaneous clear: event held through commit window
    @(negedge clk); addr = 5'd22; din = 8'h01; cs_n = 0; wr_n = 0;
    repeat (3) @(negedge clk); wr_n = 1; cs_n = 1; evt = 8'h01;
    repeat (4) @(negedge clk); evt = 8'h00;
    repeat (3) @(negedge clk);
    bus_rd(5'd22, r); check("R9 set beats clear", r, 8'h01);
    bus_wr(5'd22, 8'h01);

    // DSP bank
    @(negedge clk); dsp_evt = 8'h01; @(negedge clk); dsp_evt = 8'h00;
    repeat (2) @(negedge clk);
    check("R10 dsp irq", irq_n, 0);
    bus_rd(5'd20, r); check("R9 dsp flag", r, 8'h01);
    bus_wr(5'd20, 8'h01);
    check("R10 dsp irq cleared", irq_n, 1);

    // FIFO ports
    bus_wr(5'd18, 8'hA1);
    bus_wr(5'd18, 8'hA2, 20);
    check("R6 dec pushes", n_dec, 2);
    check("R6 dec data", last_dec, 8'hA2);
    bus_wr(5'd19, 8'hB0);
    check("R6 aux push", n_aux, 1);
    check("R6 no stray dec", n_dec, 2);
    check("R7 no pop yet", n_pop, 0);
    bus_rd(5'd18, r);
    check("R7 pop data", r, 8'h77);
    check("R7 one pop", n_pop, 1);

    busy = 1;
    bus_rd(5'd0, r); check("R8 busy bit", r, 8'h82);
    bus_rd(5'd9, r); check("R12 unmapped read", r, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule